// File: doc/BRIEF.md
# SAR Converter Sequencer

This block is the digital control core of a four-channel, 16-bit successive-approximation converter. It runs from one external clock. A two-bit select divides that clock into an internal step rate, and every sequencing action happens on a step. A conversion is requested when the active-low select line and the active-low convert line are both low. The core then runs the binary search. It exports each trial word for an external capacitor DAC and reads back a one-bit comparator decision. At the end it writes the two's complement result into an output register.

The core also handles the host side. It keeps a two-stage channel-address pipeline: the address captured for one request steers the front end only after the current conversion finishes. It also presents the result on a 16-bit data bus that can be placed in high impedance. The bus can be read as one 16-bit word, or as two bytes over its lower eight lines. The pads are driven from two enable outputs, one for each half of the bus.

Top module: `sar_conv_core`

## Requirements
- R1: `divSel` values 0, 1, 2 and 3 make one internal step every 1, 2, 4 or 8 clock cycles. All sequencing advances only on steps.
- R2: A request is seen only when `csN` and `convN` are both low. Either line low on its own starts nothing.
- R3: The first search decision is made on the first step after the request is seen. The result is committed on the 17th step. With a ratio of r, `busy` stays high for between 16r+1 and 17r clock cycles, and exactly 17 cycles when r is 1.
- R4: `busy` rises on the clock edge where the request is seen. It falls on the edge that copies the result into the output register. That register reads zero after reset.
- R5: A request that arrives while `busy` is high is ignored. It does not extend or restart the conversion, does not start another one, and does not capture an address.
- R6: `addrIn` is captured on the first clock edge after an accepted request at which `csN` or `convN` has returned high. The captured channel appears on `muxCh` when the current conversion ends. `muxCh` stays unchanged while `busy` is high.
- R7: The bus enables are active only while `csN` and `rdN` are both low and `busy` is low. During a conversion both enables are off, whatever `rdN` does.
- R8: With `byteSel` low, `dataOut[15:0]` carries the whole result and both enables follow R7. With `byteSel` high, `dataOut[7:0]` carries result bits 15..8, `dataOut[15:8]` is zero, and `oeHi` is off. `byteSel` may change while `rdN` stays low.
- R9: The search places trial bits in `dacWord` (offset binary, 0x0000 is the negative full scale) from bit 15 down to bit 0. A trial bit is kept when `cmpIn` is 1, which means the input is at or above the trial level. The stored result is that code with bit 15 inverted, so it is two's complement.
- R10: After reset, `busy` is low, `muxCh` and the pending address are channel 0, and the output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rstN | input | 1 | Active-low reset |
| divSel | input | 2 | Clock division select |
| csN | input | 1 | Active-low chip select |
| convN | input | 1 | Active-low convert request |
| rdN | input | 1 | Active-low read |
| byteSel | input | 1 | High selects the upper byte on the lower bus lines |
| addrIn | input | 2 | Channel address for the next conversion |
| cmpIn | input | 1 | Comparator decision, 1 when input is at or above the trial |
| busy | output | 1 | High while a conversion runs |
| dacWord | output | 16 | Current trial word for the DAC, offset binary |
| muxCh | output | 2 | Channel the front end samples |
| dataOut | output | 16 | Data bus value |
| oeLo | output | 1 | Drive enable for bus lines 7..0 |
| oeHi | output | 1 | Drive enable for bus lines 15..8 |

## Verification
`busy` and the bus respond on the clock edge after a request, so the bench drives inputs on falling edges and samples on the next falling edge. The bus enables and byte steering are combinational, so they are sampled one falling edge after the inputs change. The end of a conversion falls somewhere in a window that depends on the divider phase, so the monitor counts the cycles `busy` is high and checks that count against the 16r+1 to 17r window. At that same falling edge it checks `muxCh` against the scoreboard entry. The result is read only once `busy` has been seen low.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int DIVSEL_W = 2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadTrial;  // seed the search with the top trial bit
    logic decide;     // resolve the current trial bit from the comparator
    logic commit;     // copy the search word into the output register
    logic capAddr;    // capture the channel address for the next conversion
  } sarStrobes_t;
endpackage

// File: rtl/sarc_clkdiv.sv
module sarc_clkdiv #(
  parameter int DIVSEL_W = sarc_pkg::DIVSEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIVSEL_W-1:0] divSel,
  output logic                tick
);
  localparam int MAX_LOG = (1 << DIVSEL_W) - 1;
  localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(divSel));
    end
  end

  assign tick = ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  // with a fixed ratio of two, steps alternate with idle cycles
  assert_div_two_R1: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 1 && $past(divSel) == 1 && tick) |=> !tick);
endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
  import sarc_pkg::*;
#(
  parameter int DATA_W = sarc_pkg::DATA_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        csN,
  input  logic        convN,
  output logic        busy,
  output sarStrobes_t strobes
);
  localparam int STEP_W = $clog2(DATA_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DATA_W);

  typedef enum logic {ST_IDLE, ST_CONV} ctrlState_t;

  ctrlState_t        state;
  logic [STEP_W-1:0] step;
  logic              startReq;
  logic              startPrev;
  logic              startEdge;
  logic              startFall;
  logic              armed;
  logic              lastStep;

  assign startReq  = ~(csN | convN);
  assign startEdge = startReq & ~startPrev;
  assign startFall = ~startReq & startPrev;
  assign busy      = (state == ST_CONV);
  assign lastStep  = (step == LAST_STEP);

  always_comb begin
    strobes.loadTrial = (state == ST_IDLE) && startEdge;
    strobes.decide    = busy && tick && !lastStep;
    strobes.commit    = busy && tick && lastStep;
    strobes.capAddr   = startFall && armed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      step      <= '0;
      startPrev <= 1'b0;
      armed     <= 1'b0;
    end else begin
      startPrev <= startReq;
      if (startFall && armed) armed <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startEdge) begin
            state <= ST_CONV;
            step  <= '0;
            armed <= 1'b1;
          end
        end
        ST_CONV: begin
          if (tick) begin
            if (lastStep) state <= ST_IDLE;
            else          step  <= step + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // busy only ever rises after both request lines were low
  assert_start_needs_both_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!csN && !convN));

  // the search only moves on an internal step
  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> (busy && $stable(step)));

  // a request during a conversion never restarts the search
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> (step >= $past(step)));
endmodule

// File: rtl/sarc_datapath.sv
module sarc_datapath
  import sarc_pkg::*;
#(
  parameter int DATA_W = sarc_pkg::DATA_W,
  parameter int ADDR_W = sarc_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobes_t       strobes,
  input  logic              busy,
  input  logic              cmpIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              csN,
  input  logic              rdN,
  input  logic              byteSel,
  output logic [DATA_W-1:0] dacWord,
  output logic [ADDR_W-1:0] muxCh,
  output logic [DATA_W-1:0] dataOut,
  output logic              oeLo,
  output logic              oeHi
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sarWord;
  logic [DATA_W-1:0] probe;
  logic [DATA_W-1:0] result;
  logic [ADDR_W-1:0] pendCh;
  logic              drive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarWord <= '0;
      probe   <= '0;
      result  <= '0;
      pendCh  <= '0;
      muxCh   <= '0;
    end else begin
      if (strobes.loadTrial) begin
        sarWord <= TOP_BIT;
        probe   <= TOP_BIT;
      end else if (strobes.decide) begin
        sarWord <= (cmpIn ? sarWord : (sarWord & ~probe)) | (probe >> 1);
        probe   <= probe >> 1;
      end
      if (strobes.commit) begin
        result <= sarWord ^ TOP_BIT;
        muxCh  <= pendCh;
      end
      if (strobes.capAddr) pendCh <= addrIn;
    end
  end

  assign dacWord = sarWord;
  assign drive   = !csN && !rdN && !busy;
  assign oeLo    = drive;
  assign oeHi    = drive && !byteSel;
  assign dataOut = byteSel ? {{(DATA_W-HALF_W){1'b0}}, result[DATA_W-1:HALF_W]} : result;

  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(oeLo || oeHi));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || $past(strobes.commit)) || $stable(result) || $past(strobes.commit));

  assert_one_probe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(probe));

  assert_channel_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(muxCh));
endmodule

// File: rtl/sar_conv_core.sv
module sar_conv_core
  import sarc_pkg::*;
#(
  parameter int DATA_W   = sarc_pkg::DATA_W,
  parameter int ADDR_W   = sarc_pkg::ADDR_W,
  parameter int DIVSEL_W = sarc_pkg::DIVSEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIVSEL_W-1:0] divSel,
  input  logic                csN,
  input  logic                convN,
  input  logic                rdN,
  input  logic                byteSel,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                cmpIn,
  output logic                busy,
  output logic [DATA_W-1:0]   dacWord,
  output logic [ADDR_W-1:0]   muxCh,
  output logic [DATA_W-1:0]   dataOut,
  output logic                oeLo,
  output logic                oeHi
);
  logic        tick;
  sarStrobes_t strobes;

  sarc_clkdiv #(.DIVSEL_W(DIVSEL_W)) u_div (
    .clk(clk), .rstN(rstN), .divSel(divSel), .tick(tick)
  );

  sarc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .csN(csN), .convN(convN),
    .busy(busy), .strobes(strobes)
  );

  sarc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy), .cmpIn(cmpIn),
    .addrIn(addrIn), .csN(csN), .rdN(rdN), .byteSel(byteSel),
    .dacWord(dacWord), .muxCh(muxCh), .dataOut(dataOut), .oeLo(oeLo), .oeHi(oeHi)
  );
endmodule

// File: tb/sar_conv_core_tb.sv
module sar_conv_core_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [1:0]  divSel;
  logic        csN, convN, rdN, byteSel;
  logic [1:0]  addrIn;
  logic        cmpIn;
  logic        busy;
  logic [15:0] dacWord;
  logic [1:0]  muxCh;
  logic [15:0] dataOut;
  logic        oeLo, oeHi;
  logic signed [15:0] vin;

  // ideal comparator: input at or above the trial level (trial is offset binary)
  assign cmpIn = ($signed(dacWord ^ 16'h8000) <= vin);

  sar_conv_core u_dut (
    .clk(clk), .rstN(rstN), .divSel(divSel), .csN(csN), .convN(convN), .rdN(rdN),
    .byteSel(byteSel), .addrIn(addrIn), .cmpIn(cmpIn), .busy(busy), .dacWord(dacWord),
    .muxCh(muxCh), .dataOut(dataOut), .oeLo(oeLo), .oeHi(oeHi)
  );

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input string req, input string what, input bit ok,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0] nextCh;
    logic [1:0] curCh;
    int         ratio;
  } expConv_t;
  expConv_t expQ[$];
  logic [1:0] lastCh = 2'd0;

  // monitor: checks conversion length and the channel pipeline
  logic busyPrev = 1'b0;
  int   busyLen  = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !busyPrev) begin
        busyLen = 1;
        if (expQ.size() == 0) chk("R5", "unexpected conversion", 1'b0, 1, 0);
        else chk("R6", "channel held at start", muxCh == expQ[0].curCh, muxCh, expQ[0].curCh);
      end else if (busy) begin
        busyLen++;
      end else if (busyPrev && expQ.size() != 0) begin
        expConv_t e;
        e = expQ.pop_front();
        if (e.ratio == 1)
          chk("R3", "busy length ratio 1", busyLen == 17, busyLen, 17);
        else
          chk("R1", "busy length window", busyLen >= 16*e.ratio+1 && busyLen <= 17*e.ratio,
              busyLen, 17*e.ratio);
        chk("R6", "channel after end", muxCh == e.nextCh, muxCh, e.nextCh);
      end
      busyPrev = busy;
    end
  end

  task automatic readWord(input logic [15:0] exp);
    @(negedge clk); csN = 0; rdN = 0; byteSel = 0;
    @(negedge clk);
    chk("R9", "word on bus", dataOut == exp, dataOut, exp);
    chk("R8", "both halves driven", oeLo && oeHi, {oeHi, oeLo}, 2'b11);
    byteSel = 1;
    @(negedge clk);
    chk("R8", "upper byte on low lines", dataOut[7:0] == exp[15:8], dataOut[7:0], exp[15:8]);
    chk("R8", "upper half off", oeLo && !oeHi, {oeHi, oeLo}, 2'b01);
    csN = 1; rdN = 1; byteSel = 0;
  endtask

  task automatic doConv(input logic [1:0] ds, input logic signed [15:0] v,
                        input logic [1:0] nextCh, input bit probeBus, input bit lateReq);
    expConv_t e;
    @(negedge clk);
    divSel = ds; vin = v;
    e.nextCh = nextCh; e.curCh = lastCh; e.ratio = 1 << ds;
    expQ.push_back(e);
    lastCh = nextCh;
    csN = 0; convN = 0; addrIn = nextCh;
    @(negedge clk);
    chk("R4", "busy rises after request", busy == 1'b1, busy, 1);
    @(negedge clk);
    csN = 1; convN = 1;
    @(negedge clk);
    addrIn = ~nextCh;
    if (probeBus) begin
      csN = 0; rdN = 0;
      @(negedge clk); @(negedge clk);
      chk("R7", "bus off while busy", !oeLo && !oeHi, {oeHi, oeLo}, 0);
      csN = 1; rdN = 1;
    end
    if (lateReq) begin
      csN = 0; convN = 0; addrIn = 2'd3;
      @(negedge clk); @(negedge clk);
      csN = 1; convN = 1;
    end
    while (busy) @(negedge clk);
    readWord(v);
  endtask

  initial begin
    rstN = 0; divSel = 0; csN = 1; convN = 1; rdN = 1; byteSel = 0; addrIn = 0; vin = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R10", "busy after reset", busy == 0, busy, 0);
    chk("R10", "channel after reset", muxCh == 0, muxCh, 0);
    readWord(16'h0000);

    // R2: one line low alone does nothing
    @(negedge clk); csN = 0;
    repeat (4) @(negedge clk);
    chk("R2", "select alone", busy == 0, busy, 0);
    csN = 1; convN = 0;
    repeat (4) @(negedge clk);
    chk("R2", "convert alone", busy == 0, busy, 0);
    convN = 1;

    // R7: read without select is not driven
    @(negedge clk); rdN = 0;
    @(negedge clk);
    chk("R7", "read without select", !oeLo && !oeHi, {oeHi, oeLo}, 0);
    rdN = 1;

    doConv(2'd0, 16'sd12345, 2'd2, 1'b0, 1'b0);
    doConv(2'd1, -16'sd1,    2'd1, 1'b1, 1'b0);
    doConv(2'd2, 16'sd32767, 2'd3, 1'b0, 1'b0);
    doConv(2'd3, -16'sd32768, 2'd0, 1'b1, 1'b0);
    doConv(2'd0, 16'sd0,     2'd1, 1'b0, 1'b0);
    doConv(2'd3, 16'sh5555,  2'd2, 1'b0, 1'b0);

    // R5: request during conversion is ignored (no restart, no address capture)
    doConv(2'd0, -16'sd20000, 2'd1, 1'b0, 1'b1);
    repeat (300) @(negedge clk);
    chk("R5", "no second conversion", busy == 0 && expQ.size() == 0, busy, 0);
    chk("R5", "late address ignored", muxCh == 2'd1, muxCh, 1);
    doConv(2'd1, 16'sd77, 2'd0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule